// File: doc/BRIEF.md
# Power Fault Shutdown and Restart Controller

This block decides when a multi-rail power management device must drop every regulator output and when it may bring them back. It watches per-rail undervoltage and overvoltage flags, qualifies current-limit indications separately for switching and linear regulators, and tracks two die-temperature levels. It drives a global outputs-off command, a restart request to the power-up sequencer, and flags for the interrupt and reset logic. A shared prescaler supplies a microsecond tick and a millisecond tick.

An unmasked voltage fault on any rail starts a fixed off period that is measured in millisecond ticks. While that period runs, new faults are ignored. At the end of the period the controller sends a single-cycle restart request and returns to normal running. An over-temperature shutdown keeps the outputs off for as long as the shutdown flag stays high. A restart request follows once the flag clears. A temperature warning and a qualified current-limit fault raise flags and the interrupt request. They do not remove power.

Rails 0 to N_SW-1 are switching regulators. Rails N_SW to N_SW+N_LIN-1 are linear regulators. The sequencer, the analog sensing and the register interface are outside this block.

Top module: `pwr_fault_ctrl`

## Requirements
- R1: After reset, outputs_off, restart_req, sys_rst_req, irq_req, warn_flag, therm_flag and all bits of uvov_status and ilim_fault are 0.
- R2: While running, a rail with uv or ov high and its uvov_mask bit at 0 sets outputs_off, sys_rst_req and irq_req from the next clock edge on.
- R3: The off period ends on the OFF_MS-th ms_tick (default 100) counted after entry. restart_req is then high for that one cycle with outputs_off still 1. On the following cycle outputs_off is 0.
- R4: uv or ov activity during the off period neither extends nor shortens it.
- R5: A rail whose uvov_mask bit is 1 never causes outputs_off. The uvov_status bit of every rail equals uv|ov of that rail one clock later, whether the rail is masked or not.
- R6: A switching rail's ilim_fault bit goes to 1 after SW_CYC_LIMIT (default 8) sw_cycle strobes that see both sw_ilim and ss_done high, with no break in between. It then raises irq_req, and outputs_off stays 0.
- R7: Dropping sw_ilim or ss_done on a switching rail clears its count and its ilim_fault bit on the next edge. Strobes taken while ss_done is 0 are not counted.
- R8: A linear rail's ilim_fault bit goes to 1 on the (LIN_US_LIMIT+1)-th us_tick (default 21) of continuous lin_ilim with ss_done. Dropping either input clears it on the next edge.
- R9: temp_warn sets warn_flag and irq_req one cycle later and never sets outputs_off.
- R10: temp_shut while running sets outputs_off and therm_flag on the next edge. It wins over a simultaneous UV/OV fault. outputs_off stays 1 while temp_shut is high, whatever the number of ms_tick pulses. One cycle after temp_shut clears, restart_req is high for one cycle.
- R11: restart_req is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| ss_done | input | N_RAIL | Soft start finished, per rail |
| uv | input | N_RAIL | Undervoltage, per rail |
| ov | input | N_RAIL | Overvoltage, per rail |
| uvov_mask | input | N_RAIL | 1 = rail's UV/OV cannot cause shutdown |
| sw_cycle | input | N_SW | Switching-cycle strobe, per switching rail |
| sw_ilim | input | N_SW | Peak current limit hit, per switching rail |
| lin_ilim | input | N_LIN | Current limit active, per linear rail |
| temp_warn | input | 1 | Die above warning level |
| temp_shut | input | 1 | Die above shutdown level |
| outputs_off | output | 1 | Force all regulator outputs off |
| restart_req | output | 1 | One-cycle request to rerun power-up |
| sys_rst_req | output | 1 | Assert system reset |
| irq_req | output | 1 | Interrupt request |
| uvov_status | output | N_RAIL | Live UV/OV status per rail |
| ilim_fault | output | N_RAIL | Qualified current-limit fault per rail |
| warn_flag | output | 1 | Temperature warning status |
| therm_flag | output | 1 | Temperature shutdown status |

## Verification
The hardest case to reach from the ports is the exact end of the off period while fault inputs are still active. The stimulus therefore holds a second rail's overvoltage high through the first 99 millisecond ticks. It releases all fault inputs only just before the final tick, so an off period that restarted or stretched would be visible. The current-limit qualifiers are driven to one strobe or one tick below their limit. A single-cycle break is then inserted before a second run, to show that the count restarts from zero and is not merely paused.

// File: rtl/pwr_fault_pkg.sv
// Shared types and defaults for the power fault shutdown controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pwr_fault_pkg;

    // Controller phases: normal, timed fault off, thermal off, restart pulse.
    typedef enum logic [1:0] {
        ST_RUN         = 2'd0,
        ST_FAULT_OFF   = 2'd1,
        ST_THERMAL_OFF = 2'd2,
        ST_RESTART     = 2'd3
    } pf_state_t;

    localparam int DEF_N_SW         = 2;
    localparam int DEF_N_LIN        = 2;
    localparam int DEF_SW_CYC_LIMIT = 8;
    localparam int DEF_LIN_US_LIMIT = 20;
    localparam int DEF_OFF_MS       = 100;

endpackage

// File: rtl/sw_ilim_qual.sv
// Qualifies the peak current limit of one switching regulator.
// Counts switching-cycle strobes seen while the limit and soft-start-done
// are both high. Any break in either input clears the count. The fault is
// reported once CYC_LIMIT consecutive strobes have been counted.
// Assumes cyc_strobe is a single-cycle pulse per switching period.
module sw_ilim_qual #(
    parameter int CYC_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_done,
    input  logic cyc_strobe,
    input  logic ilim,
    output logic fault
);
    localparam int CNT_W = $clog2(CYC_LIMIT + 1);

    logic [CNT_W-1:0] cyc_cnt;
    logic             armed;

    assign armed = ss_done && ilim;

    // Consecutive-cycle counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            cyc_cnt <= '0;
        end else if (cyc_strobe && (cyc_cnt < CNT_W'(CYC_LIMIT))) begin
            cyc_cnt <= cyc_cnt + 1'b1;
        end
    end

    assign fault = (cyc_cnt == CNT_W'(CYC_LIMIT));

    // R7: a dropped limit or soft-start-done clears the count next cycle.
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (cyc_cnt == '0));

    // R6: the count only advances on a strobe.
    p_step_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !cyc_strobe) |=> $stable(cyc_cnt));

endmodule

// File: rtl/lin_ilim_qual.sv
// Qualifies the current limit of one linear regulator by elapsed time.
// Counts microsecond ticks while the limit and soft-start-done are both
// high. The fault is reported when more than US_LIMIT ticks have been
// counted. Any break clears the count.
// Assumes us_tick is a single-cycle pulse from a shared prescaler.
module lin_ilim_qual #(
    parameter int US_LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_done,
    input  logic us_tick,
    input  logic ilim,
    output logic fault
);
    localparam int TOP   = US_LIMIT + 1;
    localparam int CNT_W = $clog2(TOP + 1);

    logic [CNT_W-1:0] us_cnt;
    logic             armed;

    assign armed = ss_done && ilim;

    // Continuous-duration timer, saturating one step past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            us_cnt <= '0;
        end else if (us_tick && (us_cnt < CNT_W'(TOP))) begin
            us_cnt <= us_cnt + 1'b1;
        end
    end

    assign fault = (us_cnt == CNT_W'(TOP));

    // R8: a fault is only ever seen while the limit was held last cycle.
    p_fault_needs_ilim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(armed));

    // R8: releasing the limit clears the timer on the next edge.
    p_timer_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (us_cnt == '0));

endmodule

// File: rtl/fault_seq_fsm.sv
// Shutdown and restart state machine.
// RUN leaves for THERMAL_OFF on temp_shut (priority) or FAULT_OFF on an
// unmasked UV/OV trip. FAULT_OFF counts OFF_MS millisecond ticks and
// ignores all faults. THERMAL_OFF holds until temp_shut clears. Both exit
// through RESTART, which lasts exactly one cycle and then returns to RUN.
module fault_seq_fsm
    import pwr_fault_pkg::*;
#(
    parameter int OFF_MS = 100
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ms_tick,
    input  logic      trip,
    input  logic      temp_shut,
    output pf_state_t state
);
    localparam int MS_W = $clog2(OFF_MS + 1);

    pf_state_t        nxt;
    logic [MS_W-1:0]  ms_cnt;
    logic             off_done;

    assign off_done = ms_tick && (ms_cnt == MS_W'(OFF_MS - 1));

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (temp_shut)   nxt = ST_THERMAL_OFF;
                else if (trip)   nxt = ST_FAULT_OFF;
            end
            ST_FAULT_OFF:   if (off_done)   nxt = ST_RESTART;
            ST_THERMAL_OFF: if (!temp_shut) nxt = ST_RESTART;
            ST_RESTART:     nxt = ST_RUN;
            default:        nxt = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // Off-period millisecond counter, held at zero outside FAULT_OFF.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_FAULT_OFF) begin
            ms_cnt <= '0;
        end else if (ms_tick) begin
            ms_cnt <= ms_cnt + 1'b1;
        end
    end

    // R2: an unmasked trip while running with no thermal shutdown enters FAULT_OFF.
    p_trip_enters_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && trip && !temp_shut) |=> (state == ST_FAULT_OFF));

    // R4: the off period stays put until its last tick, whatever the faults.
    p_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT_OFF && !ms_tick) |=> (state == ST_FAULT_OFF));

    // R10: thermal off holds while the shutdown flag stays high.
    p_therm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_THERMAL_OFF && temp_shut) |=> (state == ST_THERMAL_OFF));

    // R10: thermal shutdown wins over a UV/OV trip in RUN.
    p_therm_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && temp_shut) |=> (state == ST_THERMAL_OFF));

    // R11: the restart phase never lasts two cycles.
    p_restart_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESTART) |=> (state == ST_RUN));

endmodule

// File: rtl/pwr_fault_ctrl.sv
// Top level of the power fault shutdown and restart controller.
// Combines per-rail UV/OV masking, per-type current-limit qualifiers and
// the shutdown state machine. It drives the global off command, the
// restart request and the interrupt and reset flags.
// Assumes all inputs are synchronous to clk, and that rails 0..N_SW-1 are
// switching regulators while the rest are linear regulators.
module pwr_fault_ctrl
    import pwr_fault_pkg::*;
#(
    parameter int N_SW         = DEF_N_SW,
    parameter int N_LIN        = DEF_N_LIN,
    parameter int SW_CYC_LIMIT = DEF_SW_CYC_LIMIT,
    parameter int LIN_US_LIMIT = DEF_LIN_US_LIMIT,
    parameter int OFF_MS       = DEF_OFF_MS,
    localparam int N_RAIL      = N_SW + N_LIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              ms_tick,
    input  logic [N_RAIL-1:0] ss_done,
    input  logic [N_RAIL-1:0] uv,
    input  logic [N_RAIL-1:0] ov,
    input  logic [N_RAIL-1:0] uvov_mask,
    input  logic [N_SW-1:0]   sw_cycle,
    input  logic [N_SW-1:0]   sw_ilim,
    input  logic [N_LIN-1:0]  lin_ilim,
    input  logic              temp_warn,
    input  logic              temp_shut,
    output logic              outputs_off,
    output logic              restart_req,
    output logic              sys_rst_req,
    output logic              irq_req,
    output logic [N_RAIL-1:0] uvov_status,
    output logic [N_RAIL-1:0] ilim_fault,
    output logic              warn_flag,
    output logic              therm_flag
);
    pf_state_t state;
    logic      trip;

    // Any rail with a live, unmasked UV or OV condition.
    assign trip = |((uv | ov) & ~uvov_mask);

    // Switching-rail current-limit qualifiers.
    for (genvar i = 0; i < N_SW; i++) begin : g_sw
        sw_ilim_qual #(.CYC_LIMIT(SW_CYC_LIMIT)) u_qual (
            .clk        (clk),
            .rst_n      (rst_n),
            .ss_done    (ss_done[i]),
            .cyc_strobe (sw_cycle[i]),
            .ilim       (sw_ilim[i]),
            .fault      (ilim_fault[i])
        );
    end

    // Linear-rail current-limit qualifiers.
    for (genvar j = 0; j < N_LIN; j++) begin : g_lin
        lin_ilim_qual #(.US_LIMIT(LIN_US_LIMIT)) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .ss_done (ss_done[N_SW + j]),
            .us_tick (us_tick),
            .ilim    (lin_ilim[j]),
            .fault   (ilim_fault[N_SW + j])
        );
    end

    fault_seq_fsm #(.OFF_MS(OFF_MS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .trip      (trip),
        .temp_shut (temp_shut),
        .state     (state)
    );

    // Live status flags, registered once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uvov_status <= '0;
            warn_flag   <= 1'b0;
            therm_flag  <= 1'b0;
        end else begin
            uvov_status <= uv | ov;
            warn_flag   <= temp_warn;
            therm_flag  <= temp_shut;
        end
    end

    assign outputs_off = (state != ST_RUN);
    assign restart_req = (state == ST_RESTART);
    assign sys_rst_req = (state == ST_FAULT_OFF) || (state == ST_THERMAL_OFF);
    assign irq_req     = sys_rst_req || warn_flag || (|ilim_fault);

    // R11: the restart request is a single-cycle pulse.
    p_restart_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);

    // R3: a restart request always leads straight back to outputs on.
    p_restart_then_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !outputs_off);

    // R5: live status tracks the raw inputs with one cycle of delay.
    p_status_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (uvov_status == $past(uv | ov)));

    // R9: a warning alone never turns outputs off.
    p_warn_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!outputs_off && !temp_shut && !trip) |=> !outputs_off);

endmodule

// File: tb/tb_pwr_fault_ctrl.sv
// Directed bench for the power fault shutdown controller.
module tb_pwr_fault_ctrl;
    localparam int N_SW = 2, N_LIN = 2, N_RAIL = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              us_tick = 1'b0, ms_tick = 1'b0;
    logic [N_RAIL-1:0] ss_done = '0, uv = '0, ov = '0, uvov_mask = '0;
    logic [N_SW-1:0]   sw_cycle = '0, sw_ilim = '0;
    logic [N_LIN-1:0]  lin_ilim = '0;
    logic              temp_warn = 1'b0, temp_shut = 1'b0;
    logic              outputs_off, restart_req, sys_rst_req, irq_req;
    logic [N_RAIL-1:0] uvov_status, ilim_fault;
    logic              warn_flag, therm_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_fault_ctrl dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ms_tick(ms_tick),
        .ss_done(ss_done), .uv(uv), .ov(ov), .uvov_mask(uvov_mask),
        .sw_cycle(sw_cycle), .sw_ilim(sw_ilim), .lin_ilim(lin_ilim),
        .temp_warn(temp_warn), .temp_shut(temp_shut),
        .outputs_off(outputs_off), .restart_req(restart_req),
        .sys_rst_req(sys_rst_req), .irq_req(irq_req),
        .uvov_status(uvov_status), .ilim_fault(ilim_fault),
        .warn_flag(warn_flag), .therm_flag(therm_flag)
    );

    // Advance n edges; the bench acts 1 ns after each edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ms_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1; step(1); ms_tick = 1'b0; step(1);
        end
    endtask

    task automatic us_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            us_tick = 1'b1; step(1); us_tick = 1'b0; step(1);
        end
    endtask

    task automatic cyc_pulses(input int rail, input int n);
        for (int k = 0; k < n; k++) begin
            sw_cycle[rail] = 1'b1; step(1); sw_cycle[rail] = 1'b0; step(1);
        end
    endtask

    task automatic t_reset;
        check("R1 outputs_off", outputs_off, 0);
        check("R1 restart_req", restart_req, 0);
        check("R1 sys_rst_req", sys_rst_req, 0);
        check("R1 irq_req", irq_req, 0);
        check("R1 flags", {warn_flag, therm_flag, uvov_status, ilim_fault}, 0);
    endtask

    task automatic t_uvov_trip;
        uv[0] = 1'b1; step(1);
        check("R2 outputs_off", outputs_off, 1);
        check("R2 sys_rst_req", sys_rst_req, 1);
        check("R2 irq_req", irq_req, 1);
        uv[0] = 1'b0; ov[1] = 1'b1;      // R4: held through the off period
        ms_pulses(99);
        check("R4 still off after 99 ms", outputs_off, 1);
        check("R4 no early restart", restart_req, 0);
        ov[1] = 1'b0;
        ms_tick = 1'b1; step(1); ms_tick = 1'b0;
        check("R3 restart pulse", restart_req, 1);
        check("R3 off during restart", outputs_off, 1);
        step(1);
        check("R3 outputs back on", outputs_off, 0);
        check("R11 restart single cycle", restart_req, 0);
        step(3);
    endtask

    task automatic t_masked;
        uvov_mask[2] = 1'b1; ov[2] = 1'b1; step(1);
        check("R5 status follows masked ov", uvov_status[2], 1);
        step(5);
        check("R5 masked rail no shutdown", outputs_off, 0);
        ov[2] = 1'b0; step(1);
        check("R5 status clears", uvov_status[2], 0);
        uvov_mask[2] = 1'b0; step(1);
    endtask

    task automatic t_sw_ilim;
        ss_done = '1; sw_ilim[0] = 1'b1; step(1);
        cyc_pulses(0, 7);
        check("R6 no fault after 7 cycles", ilim_fault[0], 0);
        cyc_pulses(0, 1);
        check("R6 fault after 8 cycles", ilim_fault[0], 1);
        check("R6 irq on ilim", irq_req, 1);
        check("R6 ilim does not turn off", outputs_off, 0);
        sw_ilim[0] = 1'b0; step(1);
        check("R7 fault clears on drop", ilim_fault[0], 0);
        sw_ilim[0] = 1'b1; step(1);
        cyc_pulses(0, 5);
        sw_ilim[0] = 1'b0; step(1); sw_ilim[0] = 1'b1; step(1);
        cyc_pulses(0, 5);
        check("R7 broken run restarts count", ilim_fault[0], 0);
        sw_ilim[0] = 1'b0; ss_done[0] = 1'b0; step(1);
        sw_ilim[0] = 1'b1; step(1);
        cyc_pulses(0, 10);
        check("R7 no count before soft start", ilim_fault[0], 0);
        sw_ilim[0] = 1'b0; ss_done = '1; step(2);
    endtask

    task automatic t_lin_ilim;
        lin_ilim[0] = 1'b1; step(1);
        us_pulses(20);
        check("R8 no fault at 20 us", ilim_fault[2], 0);
        us_pulses(1);
        check("R8 fault after 21 us", ilim_fault[2], 1);
        lin_ilim[0] = 1'b0; step(1);
        check("R8 fault clears on drop", ilim_fault[2], 0);
        step(1);
    endtask

    task automatic t_warn;
        temp_warn = 1'b1; step(1);
        check("R9 warn flag", warn_flag, 1);
        check("R9 warn irq", irq_req, 1);
        step(3);
        check("R9 warn keeps outputs on", outputs_off, 0);
        temp_warn = 1'b0; step(2);
    endtask

    task automatic t_thermal;
        temp_shut = 1'b1; uv[3] = 1'b1; step(1);
        check("R10 thermal off", outputs_off, 1);
        check("R10 therm flag", therm_flag, 1);
        uv[3] = 1'b0;
        ms_pulses(150);
        check("R10 held through ms ticks", outputs_off, 1);
        check("R10 no restart while hot", restart_req, 0);
        temp_shut = 1'b0; step(1);
        check("R10 restart after cool", restart_req, 1);
        step(1);
        check("R10 outputs on", outputs_off, 0);
        check("R11 restart single cycle", restart_req, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_uvov_trip();
        t_masked();
        t_sw_ilim();
        t_lin_ilim();
        t_warn();
        t_thermal();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule